// File: doc/BRIEF.md
# Configurable memory chip-select decoder

This block turns a 16-bit bus address into active-low chip selects for up to three byte-wide memory sockets spread over a 64K byte map. A 3-to-8 decode of the top address bits produces eight segment strobes. A 2-bit mode input sets the segment size to 8K, 16K or 32K. It does so by holding the lower decoder inputs high, so that coarser segments land on the upper decoder outputs of each group. A small per-socket map then picks which decoder output drives each socket. The topmost socket can be hard-wired to the highest output.

All outputs stay inactive unless three conditions hold: the address strobe is low, the external memory-disable line is high, and the power-good/reset line is high. An optional window comparator also turns every on-board select off across B000–B7FF, so peripheral registers there never collide with memory. The whole path is combinational: outputs follow the inputs in the same cycle, with no register in between.

Top module: `msel_decoder`

## Requirements
- R1: With mode 00 and all gating inactive, exactly decoder output N = addr[15:13] is low; each output covers one 8K segment.
- R2: With mode 01, addr[13] is treated as 1, so only outputs 1, 3, 5, 7 can go low; output 2*addr[15:14]+1 is low, each covering 16K.
- R3: With mode 10, addr[14:13] are treated as 11, so only outputs 3 and 7 can go low; output 4*addr[15]+3 is low, each covering 32K.
- R4: Mode code 11 decodes exactly as mode 00 (8K segments).
- R5: While the address strobe as_n_i is high, every decoder output and every chip select is high.
- R6: While the external disable ext_dis_n_i is low, every decoder output and every chip select is high.
- R7: While the power-good/reset line pwr_ok_i is low, every decoder output and every chip select is high.
- R8: With the window comparator enabled (default), any address with addr[15:11] = 10110 (B000–B7FF) leaves every output high; B800 and AFFF decode normally.
- R9: Socket s below the top socket follows decoder output map_i[3s+2:3s] (socket 0 in bits 2:0, socket 1 in bits 5:3); the top socket (cs_n_o[2]) follows decoder output 7. A socket mapped to an output that the current mode never drives stays high.
- R10: At most one decoder output is low at any time, and outputs respond to an input change within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 16 | Bus address |
| as_n_i | input | 1 | Address strobe, low when the address is valid for off-chip memory |
| ext_dis_n_i | input | 1 | External memory disable, low suppresses all selects |
| pwr_ok_i | input | 1 | Power-good / reset release, low suppresses all selects |
| mode_i | input | 2 | Segment size: 00 8K, 01 16K, 10 32K, 11 8K |
| map_i | input | 6 | Decoder output index for socket 0 (bits 2:0) and socket 1 (bits 5:3) |
| dec_n_o | output | 8 | Active-low decoder outputs |
| cs_n_o | output | 3 | Active-low socket chip selects |

## Verification
The assertions check on every evaluation that the decoder outputs are never more than one-hot low and that each gating input blanks them. They also check that the 16K and 32K modes never drive the even or intermediate outputs, that the 8K decode hits the addressed segment, and that the fixed top socket follows output 7. What the assertions cannot show, only the bench scenarios can: the exact segment boundaries in each mode, mode 11 aliasing to 8K, the edges of the register window (B000, B7FF against AFFF and B800), and remapped sockets that stay dark because the mode never drives their output.

// File: rtl/msel_pkg.sv
package msel_pkg;

    typedef enum logic [1:0] {
        SEG_8K   = 2'b00,
        SEG_16K  = 2'b01,
        SEG_32K  = 2'b10,
        SEG_8K_B = 2'b11
    } seg_mode_e;

    typedef struct packed {
        logic strobe_ok;
        logic ext_ok;
        logic power_ok;
        logic window_hit;
    } gate_t;

    // Number of low-order decoder inputs held high for a mode.
    function automatic logic [1:0] forced_low_bits(seg_mode_e m);
        case (m)
            SEG_16K: return 2'd1;
            SEG_32K: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic gate_open(gate_t g);
        return g.strobe_ok & g.ext_ok & g.power_ok & ~g.window_hit;
    endfunction

endpackage

// File: rtl/msel_gate.sv
module msel_gate
    import msel_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int WIN_W     = 5,
    parameter logic [WIN_W-1:0] WIN_VAL = 5'b10110,
    parameter bit WIN_EN    = 1'b1
) (
    input  logic [WIN_W-1:0] addr_hi_i,
    input  logic             as_n_i,
    input  logic             ext_dis_n_i,
    input  logic             pwr_ok_i,
    output logic             enable_o
);
    gate_t g;

    generate
        if (WIN_EN) begin : g_win
            assign g.window_hit = (addr_hi_i == WIN_VAL);
        end else begin : g_nowin
            logic unused_win_bits;
            assign unused_win_bits = ^addr_hi_i;
            assign g.window_hit    = 1'b0;
        end
    endgenerate

    assign g.strobe_ok = ~as_n_i;
    assign g.ext_ok    = ext_dis_n_i;
    assign g.power_ok  = pwr_ok_i;
    assign enable_o    = gate_open(g);

endmodule

// File: rtl/msel_segdec.sv
module msel_segdec
    import msel_pkg::*;
#(
    parameter int SEL_W   = 3,
    localparam int NUM_OUT = 1 << SEL_W
) (
    input  logic [SEL_W-1:0]   sel_i,
    input  seg_mode_e          mode_i,
    input  logic               enable_i,
    output logic [NUM_OUT-1:0] dec_n_o
);
    logic [1:0]       forced;
    logic [SEL_W-1:0] idx;

    assign forced = forced_low_bits(mode_i);

    generate
        for (genvar j = 0; j < SEL_W; j++) begin : g_bit
            assign idx[j] = (j < int'(forced)) ? 1'b1 : sel_i[j];
        end
        for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
            assign dec_n_o[i] = ~(enable_i && (idx == SEL_W'(i)));
        end
    endgenerate

endmodule

// File: rtl/msel_router.sv
module msel_router #(
    parameter int SEL_W       = 3,
    parameter int NUM_SOCKETS = 3,
    parameter bit TOP_FIXED   = 1'b1,
    localparam int NUM_OUT    = 1 << SEL_W,
    localparam int MAP_SOCK   = TOP_FIXED ? NUM_SOCKETS - 1 : NUM_SOCKETS
) (
    input  logic [NUM_OUT-1:0]        dec_n_i,
    input  logic [MAP_SOCK*SEL_W-1:0] map_i,
    output logic [NUM_SOCKETS-1:0]    cs_n_o
);
    generate
        for (genvar s = 0; s < NUM_SOCKETS; s++) begin : g_sock
            if (TOP_FIXED && s == NUM_SOCKETS - 1) begin : g_fixed
                assign cs_n_o[s] = dec_n_i[NUM_OUT-1];
            end else begin : g_mapped
                assign cs_n_o[s] = dec_n_i[map_i[s*SEL_W +: SEL_W]];
            end
        end
    endgenerate

endmodule

// File: rtl/msel_decoder.sv
module msel_decoder
    import msel_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int SEL_W       = 3,
    parameter int NUM_SOCKETS = 3,
    parameter bit TOP_FIXED   = 1'b1,
    parameter int WIN_W       = 5,
    parameter logic [WIN_W-1:0] WIN_VAL = 5'b10110,
    parameter bit WIN_EN      = 1'b1,
    localparam int NUM_OUT    = 1 << SEL_W,
    localparam int MAP_SOCK   = TOP_FIXED ? NUM_SOCKETS - 1 : NUM_SOCKETS
) (
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic                      as_n_i,
    input  logic                      ext_dis_n_i,
    input  logic                      pwr_ok_i,
    input  logic [1:0]                mode_i,
    input  logic [MAP_SOCK*SEL_W-1:0] map_i,
    output logic [NUM_OUT-1:0]        dec_n_o,
    output logic [NUM_SOCKETS-1:0]    cs_n_o
);
    logic      enable;
    seg_mode_e mode;
    logic      unused_addr_low;

    assign mode            = seg_mode_e'(mode_i);
    assign unused_addr_low = ^addr_i[ADDR_W-WIN_W-1:0];

    msel_gate #(
        .ADDR_W (ADDR_W),
        .WIN_W  (WIN_W),
        .WIN_VAL(WIN_VAL),
        .WIN_EN (WIN_EN)
    ) u_gate (
        .addr_hi_i  (addr_i[ADDR_W-1 -: WIN_W]),
        .as_n_i     (as_n_i),
        .ext_dis_n_i(ext_dis_n_i),
        .pwr_ok_i   (pwr_ok_i),
        .enable_o   (enable)
    );

    msel_segdec #(
        .SEL_W(SEL_W)
    ) u_segdec (
        .sel_i   (addr_i[ADDR_W-1 -: SEL_W]),
        .mode_i  (mode),
        .enable_i(enable),
        .dec_n_o (dec_n_o)
    );

    msel_router #(
        .SEL_W      (SEL_W),
        .NUM_SOCKETS(NUM_SOCKETS),
        .TOP_FIXED  (TOP_FIXED)
    ) u_router (
        .dec_n_i(dec_n_o),
        .map_i  (map_i),
        .cs_n_o (cs_n_o)
    );

endmodule

// File: rtl/msel_decoder_chk.sv
module msel_decoder_chk #(
    parameter int ADDR_W      = 16,
    parameter int SEL_W       = 3,
    parameter int NUM_SOCKETS = 3,
    parameter bit TOP_FIXED   = 1'b1,
    parameter int WIN_W       = 5,
    parameter logic [WIN_W-1:0] WIN_VAL = 5'b10110,
    parameter bit WIN_EN      = 1'b1,
    localparam int NUM_OUT    = 1 << SEL_W
) (
    input logic [ADDR_W-1:0]      addr_i,
    input logic                   as_n_i,
    input logic                   ext_dis_n_i,
    input logic                   pwr_ok_i,
    input logic [1:0]             mode_i,
    input logic [NUM_OUT-1:0]     dec_n_o,
    input logic [NUM_SOCKETS-1:0] cs_n_o
);
    logic in_win;
    logic [SEL_W-1:0] top_sel;
    assign in_win  = WIN_EN && (addr_i[ADDR_W-1 -: WIN_W] == WIN_VAL);
    assign top_sel = addr_i[ADDR_W-1 -: SEL_W];

    always_comb begin
        // R10
        one_low_chk: assert ($onehot0(~dec_n_o));
        // R5
        strobe_gate_chk: assert (!as_n_i || (&dec_n_o && &cs_n_o));
        // R6
        ext_dis_chk: assert (ext_dis_n_i || (&dec_n_o && &cs_n_o));
        // R7
        power_gate_chk: assert (pwr_ok_i || (&dec_n_o && &cs_n_o));
        // R8
        window_chk: assert (!in_win || &dec_n_o);
        // R2
        mode16_even_chk: assert (mode_i != 2'b01 ||
                                 (dec_n_o[0] && dec_n_o[2] && dec_n_o[4] && dec_n_o[6]));
        // R3
        mode32_chk: assert (mode_i != 2'b10 ||
                            (dec_n_o[0] && dec_n_o[1] && dec_n_o[2] &&
                             dec_n_o[4] && dec_n_o[5] && dec_n_o[6]));
        // R1
        seg8k_hit_chk: assert (!(mode_i[0] == mode_i[1] && !as_n_i && ext_dis_n_i &&
                                 pwr_ok_i && !in_win) || !dec_n_o[top_sel]);
        // R9
        top_socket_chk: assert (!TOP_FIXED || cs_n_o[NUM_SOCKETS-1] == dec_n_o[NUM_OUT-1]);
    end

endmodule

bind msel_decoder msel_decoder_chk #(
    .ADDR_W     (ADDR_W),
    .SEL_W      (SEL_W),
    .NUM_SOCKETS(NUM_SOCKETS),
    .TOP_FIXED  (TOP_FIXED),
    .WIN_W      (WIN_W),
    .WIN_VAL    (WIN_VAL),
    .WIN_EN     (WIN_EN)
) u_chk (
    .addr_i     (addr_i),
    .as_n_i     (as_n_i),
    .ext_dis_n_i(ext_dis_n_i),
    .pwr_ok_i   (pwr_ok_i),
    .mode_i     (mode_i),
    .dec_n_o    (dec_n_o),
    .cs_n_o     (cs_n_o)
);

// File: tb/msel_decoder_bench.sv
module msel_decoder_bench;

    logic        clk = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        as_n = 1'b1;
    logic        ext_dis_n = 1'b1;
    logic        pwr_ok = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [5:0]  map = {3'd6, 3'd0};
    logic [7:0]  dec_n;
    logic [2:0]  cs_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    msel_decoder u_msel_decoder (
        .addr_i     (addr),
        .as_n_i     (as_n),
        .ext_dis_n_i(ext_dis_n),
        .pwr_ok_i   (pwr_ok),
        .mode_i     (mode),
        .map_i      (map),
        .dec_n_o    (dec_n),
        .cs_n_o     (cs_n)
    );

    // Behavioural model: segment arithmetic on integer addresses.
    function automatic logic [7:0] model_dec(int a, int m, bit strb_n, bit ext_n, bit pok);
        logic [7:0] r = 8'hFF;
        int seg;
        if (strb_n || !ext_n || !pok) return r;
        if (a >= 'hB000 && a <= 'hB7FF) return r;
        case (m)
            1:       seg = (a / 16384) * 2 + 1;
            2:       seg = (a / 32768) * 4 + 3;
            default: seg = a / 8192;
        endcase
        r[seg] = 1'b0;
        return r;
    endfunction

    task automatic apply_and_check(input string tag);
        logic [7:0] ed;
        logic [2:0] ec;
        @(posedge clk);
        #1;
        @(negedge clk);
        ed = model_dec(int'(addr), int'(mode), as_n, ext_dis_n, pwr_ok);
        ec[0] = ed[map[2:0]];
        ec[1] = ed[map[5:3]];
        ec[2] = ed[7];
        checks++;
        if (dec_n !== ed || cs_n !== ec) begin
            errors++;
            $display("FAIL %s addr=%h mode=%0d dec_n=%b exp=%b cs_n=%b exp=%b",
                     tag, addr, mode, dec_n, ed, cs_n, ec);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // Reset state: power not good, strobe idle (R7)
        apply_and_check("R7 reset state");
        pwr_ok = 1'b1;
        apply_and_check("R5 strobe idle");
        as_n = 1'b0;

        // R1: 8K segments
        for (int i = 0; i < 8; i++) begin
            addr = 16'(i * 'h2000 + 'h1C5);
            apply_and_check("R1 8K segment");
        end
        addr = 16'h1FFF; apply_and_check("R1 8K upper edge");
        addr = 16'h2000; apply_and_check("R1 8K lower edge");

        // R4: mode 11 behaves as 8K
        mode = 2'b11;
        addr = 16'h4000; apply_and_check("R4 alias mode");
        addr = 16'hC123; apply_and_check("R4 alias mode");

        // R2: 16K
        mode = 2'b01;
        for (int i = 0; i < 4; i++) begin
            addr = 16'(i * 'h4000 + 'h2ABC);
            apply_and_check("R2 16K segment");
        end
        addr = 16'h0000; apply_and_check("R2 16K A13 low");

        // R3: 32K
        mode = 2'b10;
        addr = 16'h1234; apply_and_check("R3 32K lower");
        addr = 16'h7FFF; apply_and_check("R3 32K edge");
        addr = 16'hC000; apply_and_check("R3 32K upper");

        // R5 / R6 / R7 gating
        mode = 2'b00; addr = 16'h0000;
        as_n = 1'b1; apply_and_check("R5 strobe high");
        as_n = 1'b0; ext_dis_n = 1'b0; apply_and_check("R6 external disable");
        ext_dis_n = 1'b1; pwr_ok = 1'b0; apply_and_check("R7 power low");
        pwr_ok = 1'b1; apply_and_check("R7 power restored");

        // R8: register window
        addr = 16'hB000; apply_and_check("R8 window start");
        addr = 16'hB03F; apply_and_check("R8 window inside");
        addr = 16'hB7FF; apply_and_check("R8 window end");
        addr = 16'hB800; apply_and_check("R8 above window");
        addr = 16'hAFFF; apply_and_check("R8 below window");
        mode = 2'b10; addr = 16'hB400; apply_and_check("R8 window in 32K");

        // R9: socket map
        mode = 2'b01; map = {3'd6, 3'd1}; addr = 16'h0010;
        apply_and_check("R9 socket0 on output 1");
        mode = 2'b10; map = {3'd4, 3'd3}; addr = 16'h8000;
        apply_and_check("R9 socket1 unused output");
        addr = 16'h0100; apply_and_check("R9 socket0 output 3");
        mode = 2'b00; map = {3'd5, 3'd2}; addr = 16'hA000;
        apply_and_check("R9 socket1 output 5");
        addr = 16'hE000; apply_and_check("R9 top socket");

        // R10: sweep every mode, one output low at most, same-cycle response
        map = {3'd6, 3'd0};
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 64; k++) begin
                mode = 2'(m);
                addr = 16'(k * 'h0400 + 'h3);
                apply_and_check("R10 sweep");
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule